// File: doc/BRIEF.md
# Hardware Cursor Overlay with Palette

This block draws a small hardware cursor on top of a display raster. A timing generator supplies the current line and pixel numbers every clock. The block keeps the cursor image as 8-bit palette indices and a 256-entry ARGB4444 colour palette. For each raster position inside the programmed cursor rectangle and inside the active window, it sends a hit strobe and a 32-bit ARGB colour to a downstream blender.

Software controls the block over a simple register write port. The cursor image and the palette are loaded through dedicated write ports. A control bit starts a hardware sequence that fills the whole palette with a default ramp, one entry per clock. Position, size and pitch writes are held in pending copies and take effect only on a frame-start pulse, so a cursor move never tears within a frame.

Top module: `cursor_overlay`

## Requirements
- R1: While reset is held and after it is released, `hitOut` is 0, `argbOut` is 0 and `fillBusy` is 0 until the block is programmed.
- R2: Register writes decode `regAddr` as follows: 0x00 control (bit 1 starts the palette fill), 0x0C cursor position, 0x18 pitch in bytes, 0x1C size (height in bits 31:16, width in bits 15:0), 0x28 window start and 0x2C window end. Position and window registers hold the line in bits 31:16 and the pixel in bits 15:0. Writes to any other offset change nothing.
- R3: Position, size and pitch writes take effect only at a clock where `frameStart` is high. A write that falls in the same clock as `frameStart` is applied at that frame start.
- R4: A raster position is inside the cursor when posPix <= pixNum < posPix+width and posLine <= lineNum < posLine+height.
- R5: A hit also requires winStartPix <= pixNum <= winEndPix and winStartLine <= lineNum <= winEndLine, both bounds inclusive. Window writes take effect on the next clock, with no wait for a frame start.
- R6: The cursor pixel at a hit is the byte at pixmap address (lineNum-posLine)*pitch + (pixNum-posPix), taken modulo the pixmap depth. This is the same address used on the `pixAddr` write port.
- R7: A palette entry is ARGB4444, with alpha in bits 15:12, red in 11:8, green in 7:4 and blue in 3:0. The output repeats each nibble to form a byte: alpha in `argbOut[31:24]` down to blue in `argbOut[7:0]`. Without a hit, `argbOut` is 0.
- R8: `hitOut` and `argbOut` reflect the raster position presented two clocks earlier.
- R9: A control write with bit 1 set, made while no fill is running, raises `fillBusy` on the next clock. Each following clock writes one palette entry, in index order 0 to 255. Entry i gets 5*v in each nibble, where v is the matching 2-bit field of i (i[7:6] for alpha, i[5:4] red, i[3:2] green, i[1:0] blue). `fillBusy` clears after entry 255.
- R10: While `fillBusy` is high, palette writes from the `palWe` port are dropped, and a further control write with bit 1 does not restart the fill.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 6 | Register byte offset |
| regWdata | input | 32 | Register write data |
| frameStart | input | 1 | One-clock pulse at the start of a frame |
| pixWe | input | 1 | Pixmap write strobe |
| pixAddr | input | 10 | Pixmap byte address (log2 of MAX_DIM squared) |
| pixData | input | 8 | Pixmap palette index |
| palWe | input | 1 | Palette write strobe |
| palAddr | input | 8 | Palette entry index |
| palData | input | 16 | Palette entry, ARGB4444 |
| lineNum | input | 16 | Current raster line |
| pixNum | input | 16 | Current raster pixel |
| hitOut | output | 1 | Cursor covers the pixel from two clocks earlier |
| argbOut | output | 32 | Cursor colour, ARGB8888 |
| fillBusy | output | 1 | Default palette fill in progress |

## Verification
Two collisions are provoked directly. A palette write arrives on the `palWe` port while the hardware fill owns the palette, and a second fill request is made in the middle of the fill. Both are judged by scanning the cursor afterwards and by the length of `fillBusy`. The final size or position write is also issued in the same clock as `frameStart`. The raster scan that follows must show the new geometry at once. The reference model compares hit, colour and busy every clock.

// File: rtl/cursor_pkg.sv
package cursor_pkg;
  localparam int REG_AW    = 6;
  localparam int COORD_W   = 16;
  localparam int PAL_AW    = 8;
  localparam int PAL_DEPTH = 1 << PAL_AW;
  localparam int CH_W      = 4;
  localparam int PAL_DW    = 4 * CH_W;
  localparam int IDX_W     = 8;
  localparam int ARGB_W    = 4 * 2 * CH_W;

  localparam logic [REG_AW-1:0] OFF_CTRL   = 6'h00;
  localparam logic [REG_AW-1:0] OFF_POS    = 6'h0C;
  localparam logic [REG_AW-1:0] OFF_PITCH  = 6'h18;
  localparam logic [REG_AW-1:0] OFF_SIZE   = 6'h1C;
  localparam logic [REG_AW-1:0] OFF_WSTART = 6'h28;
  localparam logic [REG_AW-1:0] OFF_WEND   = 6'h2C;
  localparam int CTRL_FILL_BIT = 1;

  // line in the upper half, pixel in the lower half
  typedef struct packed {
    logic [COORD_W-1:0] line;
    logic [COORD_W-1:0] pix;
  } coord_t;

  typedef struct packed {
    coord_t             pos;
    logic [COORD_W-1:0] width;
    logic [COORD_W-1:0] height;
    logic [COORD_W-1:0] pitch;
    coord_t             winStart;
    coord_t             winEnd;
  } geom_t;

  typedef struct packed {
    logic              palWe;
    logic [PAL_AW-1:0] palAddr;
    logic [PAL_DW-1:0] palData;
  } palStrobe_t;

  // each 2-bit field v of the index becomes the nibble 5*v
  function automatic logic [PAL_DW-1:0] defaultEntry(input logic [PAL_AW-1:0] idx);
    logic [PAL_DW-1:0] e;
    for (int f = 0; f < 4; f++)
      e[CH_W*f +: CH_W] = CH_W'({2'b00, idx[2*f +: 2]} * 4'd5);
    return e;
  endfunction
endpackage

// File: rtl/cursor_ctrl.sv
module cursor_ctrl
  import cursor_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               regWe,
  input  logic [REG_AW-1:0]  regAddr,
  input  logic [31:0]        regWdata,
  input  logic               frameStart,
  input  logic               busPalWe,
  input  logic [PAL_AW-1:0]  busPalAddr,
  input  logic [PAL_DW-1:0]  busPalData,
  output geom_t              geom,
  output palStrobe_t         palOut,
  output logic               fillBusy
);
  coord_t             pendPos, actPos, nxtPos, winStart, winEnd;
  logic [COORD_W-1:0] pendW, pendH, pendPitch, actW, actH, actPitch;
  logic [COORD_W-1:0] nxtW, nxtH, nxtPitch;
  logic [PAL_AW-1:0]  fillCnt;

  logic wrPos, wrSize, wrPitch, wrCtrlFill;
  assign wrPos      = regWe && (regAddr == OFF_POS);
  assign wrSize     = regWe && (regAddr == OFF_SIZE);
  assign wrPitch    = regWe && (regAddr == OFF_PITCH);
  assign wrCtrlFill = regWe && (regAddr == OFF_CTRL) && regWdata[CTRL_FILL_BIT];

  // pending copy including a write in this very clock
  always_comb begin
    nxtPos   = wrPos   ? coord_t'(regWdata)  : pendPos;
    nxtW     = wrSize  ? regWdata[15:0]      : pendW;
    nxtH     = wrSize  ? regWdata[31:16]     : pendH;
    nxtPitch = wrPitch ? regWdata[15:0]      : pendPitch;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendPos <= '0; pendW <= '0; pendH <= '0; pendPitch <= '0;
      actPos  <= '0; actW  <= '0; actH  <= '0; actPitch  <= '0;
      winStart <= '0; winEnd <= '0;
    end else begin
      pendPos <= nxtPos; pendW <= nxtW; pendH <= nxtH; pendPitch <= nxtPitch;
      if (frameStart) begin
        actPos <= nxtPos; actW <= nxtW; actH <= nxtH; actPitch <= nxtPitch;
      end
      if (regWe && regAddr == OFF_WSTART) winStart <= coord_t'(regWdata);
      if (regWe && regAddr == OFF_WEND)   winEnd   <= coord_t'(regWdata);
    end
  end

  // default palette fill sequencer
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fillBusy <= 1'b0;
      fillCnt  <= '0;
    end else if (fillBusy) begin
      fillCnt <= fillCnt + 1'b1;
      if (fillCnt == PAL_AW'(PAL_DEPTH - 1)) fillBusy <= 1'b0;
    end else if (wrCtrlFill) begin
      fillBusy <= 1'b1;
      fillCnt  <= '0;
    end
  end

  always_comb begin
    if (fillBusy) palOut = '{palWe: 1'b1, palAddr: fillCnt, palData: defaultEntry(fillCnt)};
    else          palOut = '{palWe: busPalWe, palAddr: busPalAddr, palData: busPalData};
  end

  always_comb begin
    geom.pos      = actPos;
    geom.width    = actW;
    geom.height   = actH;
    geom.pitch    = actPitch;
    geom.winStart = winStart;
    geom.winEnd   = winEnd;
  end

  assert_fill_start_R9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(fillBusy) |-> $past(regWe && regAddr == OFF_CTRL && regWdata[CTRL_FILL_BIT]));

  assert_fill_end_R9: assert property (@(posedge clk) disable iff (!rstN)
    (fillBusy && fillCnt == PAL_AW'(PAL_DEPTH - 1)) |=> !fillBusy);

  assert_shadow_hold_R3: assert property (@(posedge clk) disable iff (!rstN)
    !$past(frameStart) |-> ($stable(actPos) && $stable(actW) && $stable(actH) && $stable(actPitch)));
endmodule

// File: rtl/cursor_datapath.sv
module cursor_datapath
  import cursor_pkg::*;
#(
  parameter int MAX_DIM = 32,
  localparam int PIX_DEPTH = MAX_DIM * MAX_DIM,
  localparam int PIX_AW    = $clog2(PIX_DEPTH)
) (
  input  logic               clk,
  input  logic               rstN,
  input  geom_t              geom,
  input  palStrobe_t         palIn,
  input  logic               pixWe,
  input  logic [PIX_AW-1:0]  pixAddr,
  input  logic [IDX_W-1:0]   pixData,
  input  logic [COORD_W-1:0] lineNum,
  input  logic [COORD_W-1:0] pixNum,
  output logic               hitOut,
  output logic [ARGB_W-1:0]  argbOut
);
  logic [IDX_W-1:0]  pixMem [PIX_DEPTH];
  logic [PAL_DW-1:0] palMem [PAL_DEPTH];

  logic              inX, inY, inWin, hitComb, hit1;
  logic [31:0]       linearAddr;
  logic [IDX_W-1:0]  pixIdx;
  logic [PAL_DW-1:0] palQ;

  always_comb begin
    inX = (pixNum >= geom.pos.pix) &&
          ({1'b0, pixNum} < ({1'b0, geom.pos.pix} + {1'b0, geom.width}));
    inY = (lineNum >= geom.pos.line) &&
          ({1'b0, lineNum} < ({1'b0, geom.pos.line} + {1'b0, geom.height}));
    inWin = (pixNum  >= geom.winStart.pix)  && (pixNum  <= geom.winEnd.pix) &&
            (lineNum >= geom.winStart.line) && (lineNum <= geom.winEnd.line);
    hitComb = inX && inY && inWin;
    linearAddr = 32'(COORD_W'(lineNum - geom.pos.line)) * 32'(geom.pitch)
               + 32'(COORD_W'(pixNum - geom.pos.pix));
  end

  always_ff @(posedge clk) begin
    if (pixWe) pixMem[pixAddr] <= pixData;
    if (palIn.palWe) palMem[palIn.palAddr] <= palIn.palData;
    pixIdx <= pixMem[linearAddr[PIX_AW-1:0]];
    palQ   <= palMem[pixIdx];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hit1   <= 1'b0;
      hitOut <= 1'b0;
    end else begin
      hit1   <= hitComb;
      hitOut <= hit1;
    end
  end

  // nibble replication into each output byte
  always_comb begin
    argbOut = '0;
    for (int k = 0; k < 4; k++)
      if (hitOut) argbOut[8*k +: 8] = {palQ[CH_W*k +: CH_W], palQ[CH_W*k +: CH_W]};
  end

  assert_latency_R8: assert property (@(posedge clk) disable iff (!rstN)
    hitOut |-> $past(hitComb, 2));

  assert_hit_window_R5: assert property (@(posedge clk) disable iff (!rstN)
    hitOut |-> ($past(pixNum, 2) >= $past(geom.winStart.pix, 2) &&
                $past(pixNum, 2) <= $past(geom.winEnd.pix, 2) &&
                $past(lineNum, 2) >= $past(geom.winStart.line, 2) &&
                $past(lineNum, 2) <= $past(geom.winEnd.line, 2)));
endmodule

// File: rtl/cursor_overlay.sv
module cursor_overlay
  import cursor_pkg::*;
#(
  parameter int MAX_DIM = 32
) (
  input  logic                                 clk,
  input  logic                                 rstN,
  input  logic                                 regWe,
  input  logic [5:0]                           regAddr,
  input  logic [31:0]                          regWdata,
  input  logic                                 frameStart,
  input  logic                                 pixWe,
  input  logic [$clog2(MAX_DIM*MAX_DIM)-1:0]   pixAddr,
  input  logic [7:0]                           pixData,
  input  logic                                 palWe,
  input  logic [7:0]                           palAddr,
  input  logic [15:0]                          palData,
  input  logic [15:0]                          lineNum,
  input  logic [15:0]                          pixNum,
  output logic                                 hitOut,
  output logic [31:0]                          argbOut,
  output logic                                 fillBusy
);
  geom_t      geom;
  palStrobe_t palStrobe;

  cursor_ctrl u_ctrl (
    .clk, .rstN, .regWe, .regAddr, .regWdata, .frameStart,
    .busPalWe(palWe), .busPalAddr(palAddr), .busPalData(palData),
    .geom, .palOut(palStrobe), .fillBusy
  );

  cursor_datapath #(.MAX_DIM(MAX_DIM)) u_dp (
    .clk, .rstN, .geom, .palIn(palStrobe), .pixWe, .pixAddr, .pixData,
    .lineNum, .pixNum, .hitOut, .argbOut
  );
endmodule

// File: tb/cursor_overlay_bench.sv
module cursor_overlay_bench;
  localparam int DIM = 32;
  localparam int PIXN = DIM * DIM;

  logic clk = 1'b0, rstN = 1'b0;
  logic regWe = 0, frameStart = 0, pixWe = 0, palWe = 0;
  logic [5:0] regAddr = 0;
  logic [31:0] regWdata = 0;
  logic [9:0] pixAddr = 0;
  logic [7:0] pixData = 0, palAddr = 0;
  logic [15:0] palData = 0, lineNum = 0, pixNum = 0;
  logic hitOut, fillBusy;
  logic [31:0] argbOut;

  always #4 clk = ~clk;

  cursor_overlay #(.MAX_DIM(DIM)) u_cursor_overlay (
    .clk, .rstN, .regWe, .regAddr, .regWdata, .frameStart, .pixWe, .pixAddr,
    .pixData, .palWe, .palAddr, .palData, .lineNum, .pixNum, .hitOut, .argbOut, .fillBusy);

  int total = 0, fails = 0, cyc = 0;
  string phaseTag = "R1";

  // reference model state
  int mPix[PIXN];
  int mPal[256];
  int pPx = 0, pPy = 0, pW = 0, pH = 0, pPitch = 0;
  int aPx = 0, aPy = 0, aW = 0, aH = 0, aPitch = 0;
  int wsx = 0, wsy = 0, wex = 0, wey = 0;
  bit mBusy = 0; int mCnt = 0;
  bit d1Hit = 0; int d1Idx = 0;

  task automatic chk(string tag, string what, int act, int exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic int widen(int e);
    int r = 0;
    for (int k = 0; k < 4; k++) r += ((e >> (4*k)) & 15) * 17 << (8*k);
    return r;
  endfunction

  function automatic int rampEntry(int i);
    return (((i>>6)&3)*5 << 12) | (((i>>4)&3)*5 << 8) | (((i>>2)&3)*5 << 4) | ((i&3)*5);
  endfunction

  task automatic tick();
    bit eHit, hitNow; int eArgb, px, ly, addr;
    eHit = d1Hit;
    eArgb = d1Hit ? widen(mPal[d1Idx]) : 0;
    px = pixNum; ly = lineNum;
    hitNow = px >= aPx && px < aPx + aW && ly >= aPy && ly < aPy + aH &&
             px >= wsx && px <= wex && ly >= wsy && ly <= wey;
    addr = ((ly - aPy) * aPitch + (px - aPx)) & (PIXN - 1);
    d1Idx = mPix[addr]; d1Hit = hitNow;
    if (regWe && regAddr == 6'h0C) begin pPy = regWdata[31:16]; pPx = regWdata[15:0]; end
    if (regWe && regAddr == 6'h1C) begin pH = regWdata[31:16]; pW = regWdata[15:0]; end
    if (regWe && regAddr == 6'h18) pPitch = regWdata[15:0];
    if (frameStart) begin aPx = pPx; aPy = pPy; aW = pW; aH = pH; aPitch = pPitch; end
    if (regWe && regAddr == 6'h28) begin wsy = regWdata[31:16]; wsx = regWdata[15:0]; end
    if (regWe && regAddr == 6'h2C) begin wey = regWdata[31:16]; wex = regWdata[15:0]; end
    if (mBusy) begin
      mPal[mCnt] = rampEntry(mCnt);
      if (mCnt == 255) mBusy = 0;
      mCnt++;
    end else begin
      if (palWe) mPal[palAddr] = palData;
      if (regWe && regAddr == 6'h00 && regWdata[1]) begin mBusy = 1; mCnt = 0; end
    end
    if (pixWe) mPix[pixAddr] = pixData;
    @(posedge clk);
    @(negedge clk);
    chk(phaseTag, "hit", int'(hitOut), int'(eHit));
    chk(phaseTag, "argb", argbOut, eArgb);
    chk("R9", "busy", int'(fillBusy), int'(mBusy));
    regWe = 0; frameStart = 0; pixWe = 0; palWe = 0;
  endtask

  task automatic regWrite(logic [5:0] a, logic [31:0] d, logic fs);
    regWe = 1; regAddr = a; regWdata = d; frameStart = fs;
    tick();
  endtask

  task automatic scan(int x0, int x1, int y0, int y1);
    for (int y = y0; y <= y1; y++)
      for (int x = x0; x <= x1; x++) begin
        lineNum = 16'(y); pixNum = 16'(x);
        tick();
      end
    tick(); tick();
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      total++; fails++;
      $display("FAIL watchdog: actual %0d expected <150000 cycles", cyc);
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < PIXN; i++) mPix[i] = 0;
    for (int i = 0; i < 256; i++) mPal[i] = 0;
    repeat (3) @(negedge clk);
    chk("R1", "hit in reset", int'(hitOut), 0);
    chk("R1", "argb in reset", argbOut, 0);
    chk("R1", "busy in reset", int'(fillBusy), 0);
    rstN = 1;
    phaseTag = "R1";
    repeat (3) tick();

    phaseTag = "R6";
    for (int a = 0; a < PIXN; a++) begin
      pixWe = 1; pixAddr = 10'(a); pixData = 8'((a * 37 + 11) & 255);
      tick();
    end

    // fill, with a colliding palette write and a second request (R10)
    phaseTag = "R9";
    regWrite(6'h00, 32'h2, 0);
    for (int k = 0; k < 270; k++) begin
      if (k == 10) begin phaseTag = "R10"; palWe = 1; palAddr = 8'd5; palData = 16'hFFFF; end
      if (k == 20) begin regWe = 1; regAddr = 6'h00; regWdata = 32'h2; end
      tick();
    end
    chk("R10", "fill length", int'(fillBusy), 0);

    // geometry; size write shares the clock with frameStart (R3)
    phaseTag = "R2";
    regWrite(6'h28, 32'h0, 0);
    regWrite(6'h2C, (479 << 16) | 639, 0);
    regWrite(6'h0C, (20 << 16) | 10, 0);
    regWrite(6'h18, 32'd16, 0);
    phaseTag = "R3";
    regWrite(6'h1C, (8 << 16) | 16, 1);
    phaseTag = "R4";
    scan(8, 27, 18, 29);

    phaseTag = "R7";
    for (int i = 0; i < 256; i++) begin
      palWe = 1; palAddr = 8'(i); palData = 16'((i * 40503 + 4660) & 65535);
      tick();
    end
    scan(8, 27, 18, 29);

    phaseTag = "R3";
    regWrite(6'h0C, (40 << 16) | 30, 0);
    scan(8, 27, 18, 29);
    frameStart = 1; tick();
    scan(28, 47, 38, 49);

    phaseTag = "R6";
    regWrite(6'h18, 32'd32, 1);
    scan(28, 47, 38, 49);

    phaseTag = "R5";
    regWrite(6'h28, (42 << 16) | 33, 0);
    regWrite(6'h2C, (45 << 16) | 40, 0);
    scan(28, 47, 38, 49);

    phaseTag = "R2";
    regWrite(6'h10, 32'h0, 1);
    regWrite(6'h04, 32'hFFFF_FFFF, 1);
    regWrite(6'h08, 32'h0, 1);
    scan(28, 47, 38, 49);

    phaseTag = "R8";
    regWrite(6'h28, 32'h0, 0);
    regWrite(6'h2C, (479 << 16) | 639, 0);
    for (int k = 0; k < 300; k++) begin
      pixNum = 16'(25 + (k * 13) % 30); lineNum = 16'(35 + (k * 7) % 20);
      tick();
    end

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule